// File: doc/BRIEF.md
# Host-to-local memory bus arbiter

This block lets a synchronous host slave port share one local memory bus with an embedded controller that fetches from FLASH and works in SRAM. The host presents one of four command strobes with an address and, for writes, data. A write is taken into a one-entry posted buffer and acknowledged at once, even while the controller is using the bus. A read holds the host in wait state, with `h_ready` low, until the SRAM data has been fetched. The data is then driven with an output enable until the host releases its strobe.

Two state machines do the work. The host-side machine has the states HS_IDLE, HS_RDWAIT, HS_WRWAIT and HS_HOLD:
- HS_IDLE goes to HS_HOLD on a write when the buffer is free.
- HS_IDLE goes to HS_WRWAIT on a write when the buffer is full.
- HS_IDLE goes to HS_RDWAIT on a read.
- HS_WRWAIT goes to HS_HOLD once the buffer empties.
- HS_RDWAIT goes to HS_HOLD when the read access ends.
- HS_HOLD returns to HS_IDLE once no strobe is active.

The bus-side machine has the states BS_IDLE, BS_CTRL, BS_POST and BS_HREAD. BS_IDLE arbitrates and moves to one of the three access states: a controller access, the posted write, or the host read. Each access state returns to BS_IDLE when its wait-state counter reaches zero. Arbitration alternates between the controller and the host path. Within the host path, the posted write always precedes the read.

Top module: `host_mem_arbiter`

## Requirements
- R1: A command exists only when exactly one of `h_memrd`, `h_memwr`, `h_iord`, `h_iowr` is high. `h_memrd`/`h_iord` are reads and `h_memwr`/`h_iowr` are writes. No strobe, or two or more strobes, is ignored: `h_ready` stays low and no local access starts. `lb_io` is 1 during host accesses from the I/O strobes and 0 otherwise.
- R2: During and right after reset, `h_ready`, `h_rdata_oe`, `h_rdata`, `lb_act`, `lb_we` and `c_gnt` are all 0.
- R3: A host write that finds the buffer empty is captured at the first clock edge that samples the strobe. `h_ready` is high after that edge, whatever the controller is doing. The write later runs on the local bus with `lb_we` high.
- R4: A host write that finds the buffer full keeps `h_ready` low until the buffered write has finished on the local bus. It is then captured one edge later.
- R5: A host read keeps `h_ready` low until its data has been fetched. With the bus idle and nothing pending, `h_ready` is first high after edge N+3, counting the strobe-sampling edge as edge 1. N is `ws_sram`.
- R6: Every local access holds `lb_act` for exactly 1+N cycles. N is `ws_flash` for controller accesses with `c_flash`=1 and `ws_sram` for all others. At least one cycle with `lb_act` low separates two accesses.
- R7: In an idle cycle where both the controller (`c_req`) and the host path request, the side not granted last wins. After reset, a tie goes to the controller. A lone requester always wins.
- R8: A pending posted write is granted before a pending host read, and the read returns the posted data.
- R9: `h_rdata_oe` is high with `h_ready` for a completed read. It stays high while the read strobe is held and falls one cycle after the strobes are released. `h_rdata` is 0 whenever `h_rdata_oe` is low.
- R10: During a controller access, `c_gnt` is high, `lb_addr` equals `c_addr` as sampled at the grant, and `lb_flash` equals `c_flash` as sampled at the grant. `lb_flash` is 0 at all other times.
- R11: Suppose a read arrives behind a posted write while a controller access is running and `c_req` stays high. The bus order is then: the running controller access, the posted write, one more controller access, and then the read. With both counts at 3, the read arriving in the last controller cycle sees `h_ready` first after edge 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_memrd | input | 1 | Host memory read strobe |
| h_memwr | input | 1 | Host memory write strobe |
| h_iord | input | 1 | Host I/O read strobe |
| h_iowr | input | 1 | Host I/O write strobe |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, 0 when not driven |
| h_rdata_oe | output | 1 | Host read data drive enable |
| h_ready | output | 1 | Host command complete; low means wait state |
| c_req | input | 1 | Controller bus request |
| c_flash | input | 1 | Controller target: 1 FLASH, 0 SRAM |
| c_addr | input | AW | Controller address |
| c_gnt | output | 1 | Controller access in progress |
| ws_flash | input | WSW | FLASH wait-state count |
| ws_sram | input | WSW | SRAM wait-state count |
| lb_act | output | 1 | Local bus access active |
| lb_we | output | 1 | Local write (posted host write) |
| lb_io | output | 1 | Local host access is in I/O space |
| lb_flash | output | 1 | Local access targets FLASH |
| lb_addr | output | AW | Local address |
| lb_wdata | output | DW | Local write data |
| lb_rdata | input | DW | Local read data |

## Verification
The assertions assume the host keeps its strobe, address and data steady from the first sampling edge until it sees `h_ready`. They also assume the host removes the strobe within a bounded time after that. The controller is assumed to hold `c_addr` and `c_flash` valid while `c_req` is high. The bench drives every input on the falling edge and changes host inputs only between commands. It also models the SRAM as a combinational array on `lb_addr`, so the read data captured at the last access cycle is well defined.

// File: rtl/hma_pkg.sv
package hma_pkg;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_RDWAIT,
        HS_WRWAIT,
        HS_HOLD
    } host_st_e;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_CTRL,
        BS_POST,
        BS_HREAD
    } bus_st_e;

endpackage

// File: rtl/hma_strobe_dec.sv
module hma_strobe_dec (
    input  logic memrd,
    input  logic memwr,
    input  logic iord,
    input  logic iowr,
    output logic cmd_rd,
    output logic cmd_wr,
    output logic cmd_io,
    output logic cmd_any
);
    localparam int NSTB = 4;

    logic [NSTB-1:0] stb;
    logic            single;

    always_comb begin
        stb     = {memrd, memwr, iord, iowr};
        single  = ($countones(stb) == 1);
        cmd_rd  = single && (memrd || iord);
        cmd_wr  = single && (memwr || iowr);
        cmd_io  = iord || iowr;
        cmd_any = |stb;
    end
endmodule

// File: rtl/hma_post_buf.sv
module hma_post_buf #(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          drain,
    input  logic [AW-1:0] in_addr,
    input  logic [DW-1:0] in_data,
    input  logic          in_io,
    output logic          vld,
    output logic [AW-1:0] q_addr,
    output logic [DW-1:0] q_data,
    output logic          q_io
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld    <= 1'b0;
            q_addr <= '0;
            q_data <= '0;
            q_io   <= 1'b0;
        end else if (load) begin
            vld    <= 1'b1;
            q_addr <= in_addr;
            q_data <= in_data;
            q_io   <= in_io;
        end else if (drain) begin
            vld    <= 1'b0;
        end
    end
endmodule

// File: rtl/hma_wait_ctr.sv
module hma_wait_ctr #(
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [WSW-1:0] start_val,
    output logic           zero
);
    logic [WSW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= start_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/hma_grant.sv
module hma_grant (
    input  logic en,
    input  logic c_req,
    input  logic post_pend,
    input  logic rd_pend,
    input  logic last_host,
    output logic g_ctrl,
    output logic g_post,
    output logic g_read
);
    logic host_want;
    logic pick_host;

    always_comb begin
        host_want = post_pend || rd_pend;
        pick_host = host_want && (!c_req || !last_host);
        g_ctrl    = en && c_req && !pick_host;
        g_post    = en && pick_host && post_pend;
        g_read    = en && pick_host && !post_pend;
    end
endmodule

// File: rtl/host_mem_arbiter.sv
module host_mem_arbiter
    import hma_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_memrd,
    input  logic           h_memwr,
    input  logic           h_iord,
    input  logic           h_iowr,
    input  logic [AW-1:0]  h_addr,
    input  logic [DW-1:0]  h_wdata,
    output logic [DW-1:0]  h_rdata,
    output logic           h_rdata_oe,
    output logic           h_ready,
    input  logic           c_req,
    input  logic           c_flash,
    input  logic [AW-1:0]  c_addr,
    output logic           c_gnt,
    input  logic [WSW-1:0] ws_flash,
    input  logic [WSW-1:0] ws_sram,
    output logic           lb_act,
    output logic           lb_we,
    output logic           lb_io,
    output logic           lb_flash,
    output logic [AW-1:0]  lb_addr,
    output logic [DW-1:0]  lb_wdata,
    input  logic [DW-1:0]  lb_rdata
);
    host_st_e hs_q, hs_d;
    bus_st_e  bs_q, bs_d;

    logic cmd_rd, cmd_wr, cmd_io, cmd_any;
    logic post_vld, post_io, post_load, post_drain;
    logic [AW-1:0] post_addr;
    logic [DW-1:0] post_data;
    logic g_ctrl, g_post, g_read, g_any;
    logic ctr_zero, acc_last, read_fin;
    logic [WSW-1:0] start_val;

    logic          rd_pend_q, rd_io_q, hold_rd_q, last_host_q, cfl_q;
    logic [AW-1:0] rd_addr_q, ca_q;
    logic [DW-1:0] rdata_q;

    hma_strobe_dec u_dec (
        .memrd   (h_memrd),
        .memwr   (h_memwr),
        .iord    (h_iord),
        .iowr    (h_iowr),
        .cmd_rd  (cmd_rd),
        .cmd_wr  (cmd_wr),
        .cmd_io  (cmd_io),
        .cmd_any (cmd_any)
    );

    hma_post_buf #(.AW(AW), .DW(DW)) u_pbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (post_load),
        .drain   (post_drain),
        .in_addr (h_addr),
        .in_data (h_wdata),
        .in_io   (cmd_io),
        .vld     (post_vld),
        .q_addr  (post_addr),
        .q_data  (post_data),
        .q_io    (post_io)
    );

    hma_grant u_grant (
        .en        (bs_q == BS_IDLE),
        .c_req     (c_req),
        .post_pend (post_vld),
        .rd_pend   (rd_pend_q),
        .last_host (last_host_q),
        .g_ctrl    (g_ctrl),
        .g_post    (g_post),
        .g_read    (g_read)
    );

    assign g_any     = g_ctrl || g_post || g_read;
    assign start_val = (g_ctrl && c_flash) ? ws_flash : ws_sram;

    hma_wait_ctr #(.WSW(WSW)) u_wctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (g_any),
        .start_val (start_val),
        .zero      (ctr_zero)
    );

    assign acc_last   = (bs_q != BS_IDLE) && ctr_zero;
    assign post_drain = (bs_q == BS_POST) && acc_last;
    assign read_fin   = (bs_q == BS_HREAD) && acc_last;
    assign post_load  = !post_vld &&
                        (((hs_q == HS_IDLE) && cmd_wr) || (hs_q == HS_WRWAIT));

    // state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q <= HS_IDLE;
            bs_q <= BS_IDLE;
        end else begin
            hs_q <= hs_d;
            bs_q <= bs_d;
        end
    end

    // host-side next state
    always_comb begin
        hs_d = hs_q;
        unique case (hs_q)
            HS_IDLE: begin
                if (cmd_wr)      hs_d = post_vld ? HS_WRWAIT : HS_HOLD;
                else if (cmd_rd) hs_d = HS_RDWAIT;
            end
            HS_RDWAIT: if (read_fin)  hs_d = HS_HOLD;
            HS_WRWAIT: if (!post_vld) hs_d = HS_HOLD;
            HS_HOLD:   if (!cmd_any)  hs_d = HS_IDLE;
            default:   hs_d = HS_IDLE;
        endcase
    end

    // bus-side next state
    always_comb begin
        bs_d = bs_q;
        unique case (bs_q)
            BS_IDLE: begin
                if (g_post)      bs_d = BS_POST;
                else if (g_read) bs_d = BS_HREAD;
                else if (g_ctrl) bs_d = BS_CTRL;
            end
            BS_CTRL, BS_POST, BS_HREAD: if (ctr_zero) bs_d = BS_IDLE;
            default: bs_d = BS_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q   <= 1'b0;
            rd_io_q     <= 1'b0;
            rd_addr_q   <= '0;
            rdata_q     <= '0;
            hold_rd_q   <= 1'b0;
            last_host_q <= 1'b1;
            ca_q        <= '0;
            cfl_q       <= 1'b0;
        end else begin
            if ((hs_q == HS_IDLE) && cmd_rd) begin
                rd_pend_q <= 1'b1;
                rd_addr_q <= h_addr;
                rd_io_q   <= cmd_io;
            end else if (read_fin) begin
                rd_pend_q <= 1'b0;
            end
            if (read_fin) begin
                rdata_q   <= lb_rdata;
                hold_rd_q <= 1'b1;
            end else if (post_load) begin
                hold_rd_q <= 1'b0;
            end
            if (g_ctrl) begin
                last_host_q <= 1'b0;
                ca_q        <= c_addr;
                cfl_q       <= c_flash;
            end else if (g_post || g_read) begin
                last_host_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        h_ready    = (hs_q == HS_HOLD);
        h_rdata_oe = h_ready && hold_rd_q;
        h_rdata    = h_rdata_oe ? rdata_q : '0;
        c_gnt      = (bs_q == BS_CTRL);
        lb_act     = (bs_q != BS_IDLE);
        lb_we      = (bs_q == BS_POST);
        lb_flash   = c_gnt && cfl_q;
        lb_addr    = '0;
        lb_wdata   = '0;
        lb_io      = 1'b0;
        unique case (bs_q)
            BS_CTRL:  lb_addr = ca_q;
            BS_POST: begin
                lb_addr  = post_addr;
                lb_wdata = post_data;
                lb_io    = post_io;
            end
            BS_HREAD: begin
                lb_addr = rd_addr_q;
                lb_io   = rd_io_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hma_checker.sv
module hma_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          h_memrd,
    input logic          h_memwr,
    input logic          h_iord,
    input logic          h_iowr,
    input logic          h_ready,
    input logic          h_rdata_oe,
    input logic          c_gnt,
    input logic          lb_act,
    input logic          lb_we,
    input logic          lb_flash,
    input logic [AW-1:0] lb_addr,
    input logic          acc_last,
    input logic          post_vld
);
    logic rd_only;
    assign rd_only = ($countones({h_memrd, h_memwr, h_iord, h_iowr}) == 1) &&
                     (h_memrd || h_iord);

    assert_oe_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_rdata_oe |-> h_ready);

    assert_oe_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rdata_oe && rd_only) |=> h_rdata_oe);

    assert_single_owner_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_gnt || lb_we) |-> ($onehot0({c_gnt, lb_we}) && lb_act));

    assert_flash_ctrl_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lb_flash |-> c_gnt);

    assert_idle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_last |=> !lb_act);

    assert_addr_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_act && !acc_last) |=> (lb_act && $stable(lb_addr)));

    assert_write_drains_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lb_we && acc_last) |=> !post_vld);

    assert_no_write_without_post_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lb_we |-> post_vld);
endmodule

bind host_mem_arbiter hma_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .h_memrd    (h_memrd),
    .h_memwr    (h_memwr),
    .h_iord     (h_iord),
    .h_iowr     (h_iowr),
    .h_ready    (h_ready),
    .h_rdata_oe (h_rdata_oe),
    .c_gnt      (c_gnt),
    .lb_act     (lb_act),
    .lb_we      (lb_we),
    .lb_flash   (lb_flash),
    .lb_addr    (lb_addr),
    .acc_last   (acc_last),
    .post_vld   (post_vld)
);

// File: tb/host_mem_arbiter_tb.sv
module host_mem_arbiter_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int WSW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_memrd = 0, h_memwr = 0, h_iord = 0, h_iowr = 0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0;
    logic [DW-1:0] h_rdata;
    logic h_rdata_oe, h_ready;
    logic c_req = 0, c_flash = 0;
    logic [AW-1:0] c_addr = '0;
    logic c_gnt;
    logic [WSW-1:0] ws_flash = 2'd2, ws_sram = 2'd1;
    logic lb_act, lb_we, lb_io, lb_flash;
    logic [AW-1:0] lb_addr;
    logic [DW-1:0] lb_wdata, lb_rdata;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    host_mem_arbiter #(.AW(AW), .DW(DW), .WSW(WSW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .h_memrd(h_memrd), .h_memwr(h_memwr), .h_iord(h_iord), .h_iowr(h_iowr),
        .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .h_rdata_oe(h_rdata_oe), .h_ready(h_ready),
        .c_req(c_req), .c_flash(c_flash), .c_addr(c_addr), .c_gnt(c_gnt),
        .ws_flash(ws_flash), .ws_sram(ws_sram),
        .lb_act(lb_act), .lb_we(lb_we), .lb_io(lb_io), .lb_flash(lb_flash),
        .lb_addr(lb_addr), .lb_wdata(lb_wdata), .lb_rdata(lb_rdata)
    );

    // local memory
    logic [DW-1:0] mem [0:255];
    initial for (int i = 0; i < 256; i++) mem[i] = DW'(i * 257) ^ 16'h5a5a;
    assign lb_rdata = mem[lb_addr[7:0]];
    always @(posedge clk) if (lb_act && lb_we) mem[lb_addr[7:0]] <= lb_wdata;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_hs, m_bs, m_cnt;
    bit  m_rd, m_pv, m_rp, m_lh, m_cfl, m_pio, m_rio;
    logic [AW-1:0] m_pa, m_ra, m_ca;
    logic [DW-1:0] m_pd, m_rdat;

    always @(posedge clk) begin
        int  n;
        bit  rd, wr, io, pv0, rfin, toh;
        if (!rst_n) begin
            m_hs = 0; m_bs = 0; m_cnt = 0; m_rd = 0; m_pv = 0; m_rp = 0; m_lh = 1;
            m_cfl = 0; m_pio = 0; m_rio = 0; m_pa = '0; m_ra = '0; m_ca = '0;
            m_pd = '0; m_rdat = '0;
        end else begin
            n    = int'(h_memrd) + int'(h_memwr) + int'(h_iord) + int'(h_iowr);
            rd   = (n == 1) && (h_memrd || h_iord);
            wr   = (n == 1) && (h_memwr || h_iowr);
            io   = h_iord || h_iowr;
            pv0  = m_pv;
            rfin = 0;
            if (m_bs == 0) begin
                toh = (m_pv || m_rp) && (!c_req || !m_lh);
                if (toh) begin
                    m_bs = m_pv ? 2 : 3; m_cnt = int'(ws_sram); m_lh = 1;
                end else if (c_req) begin
                    m_bs = 1; m_cnt = c_flash ? int'(ws_flash) : int'(ws_sram);
                    m_lh = 0; m_ca = c_addr; m_cfl = c_flash;
                end
            end else if (m_cnt == 0) begin
                if (m_bs == 2) m_pv = 0;
                if (m_bs == 3) begin m_rdat = mem[m_ra[7:0]]; m_rp = 0; rfin = 1; end
                m_bs = 0;
            end else begin
                m_cnt--;
            end
            case (m_hs)
                0: if (wr) begin
                       if (!pv0) begin
                           m_pv = 1; m_pa = h_addr; m_pd = h_wdata; m_pio = io; m_hs = 3; m_rd = 0;
                       end else m_hs = 2;
                   end else if (rd) begin
                       m_rp = 1; m_ra = h_addr; m_rio = io; m_hs = 1;
                   end
                1: if (rfin) begin m_hs = 3; m_rd = 1; end
                2: if (!pv0) begin
                       m_pv = 1; m_pa = h_addr; m_pd = h_wdata; m_pio = io; m_hs = 3; m_rd = 0;
                   end
                default: if (n == 0) m_hs = 0;
            endcase
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        logic [AW-1:0] ea;
        if (rst_n) begin
            ea = (m_bs == 1) ? m_ca : (m_bs == 2) ? m_pa : (m_bs == 3) ? m_ra : '0;
            chk("R5", "h_ready", 32'(h_ready), 32'(m_hs == 3));
            chk("R9", "h_rdata_oe", 32'(h_rdata_oe), 32'(m_hs == 3 && m_rd));
            chk("R9", "h_rdata", 32'(h_rdata), (m_hs == 3 && m_rd) ? 32'(m_rdat) : 32'd0);
            chk("R6", "lb_act", 32'(lb_act), 32'(m_bs != 0));
            chk("R8", "lb_we", 32'(lb_we), 32'(m_bs == 2));
            chk("R7", "c_gnt", 32'(c_gnt), 32'(m_bs == 1));
            chk("R10", "lb_flash", 32'(lb_flash), 32'(m_bs == 1 && m_cfl));
            chk("R10", "lb_addr", 32'(lb_addr), 32'(ea));
            chk("R1", "lb_io", 32'(lb_io), (m_bs == 2) ? 32'(m_pio) : (m_bs == 3) ? 32'(m_rio) : 32'd0);
            chk("R3", "lb_wdata", 32'(lb_wdata), (m_bs == 2) ? 32'(m_pd) : 32'd0);
        end
    end

    int gnt_rises;
    bit we_seen;

    task automatic host_cmd(input bit wr, input bit io, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, output int lat);
        bit prev;
        @(negedge clk);
        h_addr = a; h_wdata = d;
        h_memrd = !wr && !io; h_iord = !wr && io;
        h_memwr = wr && !io;  h_iowr = wr && io;
        lat = 0; gnt_rises = 0; we_seen = 0; prev = c_gnt;
        do begin
            @(negedge clk);
            lat++;
            if (c_gnt && !prev) gnt_rises++;
            prev = c_gnt;
            if (lb_we) we_seen = 1;
        end while (!h_ready && lat < 200);
    endtask

    task automatic release_cmd();
        h_memrd = 0; h_memwr = 0; h_iord = 0; h_iowr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        chk("R2", "h_ready in reset", 32'(h_ready), 0);
        chk("R2", "lb_act in reset", 32'(lb_act), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", "h_ready after reset", 32'(h_ready), 0);
        chk("R2", "h_rdata_oe after reset", 32'(h_rdata_oe), 0);
        chk("R2", "h_rdata after reset", 32'(h_rdata), 0);
        chk("R2", "c_gnt after reset", 32'(c_gnt), 0);
        chk("R2", "lb_we after reset", 32'(lb_we), 0);

        // posted write, free buffer
        host_cmd(1, 0, 16'h000a, 16'h1234, lat);
        chk("R3", "posted write latency", lat, 1);
        release_cmd(); idle(8);

        // read latency over every SRAM wait count
        for (int w = 0; w < 4; w++) begin
            ws_sram = WSW'(w);
            host_cmd(0, 0, 16'h000a, 16'h0, lat);
            chk("R5", "read latency", lat, w + 3);
            chk("R8", "read returns posted data", 32'(h_rdata), 32'h1234);
            @(negedge clk);
            chk("R9", "oe held while strobe held", 32'(h_rdata_oe), 1);
            release_cmd();
            @(negedge clk);
            chk("R9", "oe after release", 32'(h_rdata_oe), 0);
            chk("R9", "h_rdata after release", 32'(h_rdata), 0);
            idle(3);
        end

        // I/O space write and read back
        ws_sram = 2'd2;
        host_cmd(1, 1, 16'h0014, 16'hbeef, lat);
        release_cmd(); idle(6);
        host_cmd(0, 1, 16'h0014, 16'h0, lat);
        chk("R1", "I/O read data", 32'(h_rdata), 32'hbeef);
        release_cmd(); idle(3);

        // two strobes at once are ignored
        @(negedge clk);
        h_memrd = 1; h_memwr = 1; h_addr = 16'h0021;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R1", "ready with two strobes", 32'(h_ready), 0);
            chk("R1", "lb_act with two strobes", 32'(lb_act), 0);
        end
        release_cmd(); idle(3);

        // second write while buffer full
        ws_sram = 2'd3;
        host_cmd(1, 0, 16'h0028, 16'h1111, lat);
        chk("R3", "first write latency", lat, 1);
        release_cmd();
        host_cmd(1, 0, 16'h0029, 16'h2222, lat);
        chk("R4", "second write waits for drain", lat, 5);
        release_cmd(); idle(10);
        host_cmd(0, 0, 16'h0028, 16'h0, lat);
        chk("R8", "first buffered write landed", 32'(h_rdata), 32'h1111);
        release_cmd(); idle(2);
        host_cmd(0, 0, 16'h0029, 16'h0, lat);
        chk("R4", "second buffered write landed", 32'(h_rdata), 32'h2222);
        release_cmd(); idle(4);

        // worst-case interleave with the controller
        ws_flash = 2'd3; ws_sram = 2'd3;
        @(negedge clk);
        c_req = 1; c_flash = 1; c_addr = 16'h004d;
        lat = 0;
        while (!c_gnt && lat < 50) begin @(negedge clk); lat++; end
        chk("R10", "controller address on bus", 32'(lb_addr), 32'h004d);
        chk("R10", "controller flash select", 32'(lb_flash), 1);
        host_cmd(1, 0, 16'h0032, 16'h3333, lat);
        chk("R3", "write posted while controller owns bus", lat, 1);
        release_cmd();
        host_cmd(0, 0, 16'h0032, 16'h0, lat);
        chk("R11", "read latency behind write and controller", lat, 16);
        chk("R7", "controller accesses during read wait", gnt_rises, 1);
        chk("R8", "posted write ran before read", 32'(we_seen), 1);
        chk("R8", "read sees posted data", 32'(h_rdata), 32'h3333);
        release_cmd();
        @(negedge clk);
        c_req = 0;
        idle(12);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule